// File: doc/BRIEF.md
# TDM Transmit Frame Aligner

This block serialises parallel words onto a time-division-multiplexed transmit line and places the first bit of each frame at a programmed distance from an incoming frame sync. It runs on a clock at twice the bit rate. Successive edges of that clock stand for the rising and falling edges of the bit clock, which the block also drives out. As a result, a half-bit offset is a single clock cycle, and both bit-clock edges are handled by one synchronous design.

Configuration selects the bit-clock edge on which the sync is sampled, the edge on which data is launched, the active level of the sync, a delay count and the frame length in bits. The offset from the sync sample to the first data bit is two cycles per unit of delay, minus two, plus one more cycle when the sync edge and the data edge differ. A delay of zero places the first bit before the sync that marks it. That bit is therefore predicted by a free-running counter, two ticks per bit, that is re-aligned by every detected sync.

Words arrive over a valid/ready handshake into a one-word staging register. They leave most significant bit first, back to back. If no word is ready at a word boundary, the block sends all ones for that word and raises an underrun pulse.

Top module: `tdm_tx_aligner`

## Requirements
- R1: Each clock edge alternates between a rising-edge event and a falling-edge event of the bit clock. The first edge after reset release is a rising event. `bclk_o` reads 1 after a rising event and 0 after a falling event.
- R2: The sync is sampled only on events of the kind set by `cfg_sync_edge` (0 = rising, 1 = falling). Its active level is high when `cfg_sync_low` is 0 and low when it is 1. A frame sync is detected when one sample is active and the sample before it was inactive.
- R3: With delay D of 1 or more, the first bit of the frame leaves on the clock edge 2·D − 2 + X cycles after the sync detection edge. X is 1 when the two edge selects differ and 0 otherwise.
- R4: With D = 0, the first sync starts no frame at once. The first frame bit leaves 2·L − 2 + X cycles after that sync, where L is `cfg_frame_len`, which is ahead of the next sync sample.
- R5: Until a sync has been detected, `txd_o` stays 1 and `frame_start_o` stays 0.
- R6: Words go out most significant bit first, one bit per data-edge event, and each word follows the previous one with no gap.
- R7: `word_ready` is 1 exactly when the staging register is empty and either no word has left since reset or the current word is on its last bit. A word is taken on a clock edge where `word_valid` and `word_ready` are both 1.
- R8: At a word boundary with no staged or offered word, the block sends all ones for that word and `underrun_o` is 1 while the first of those ones is on `txd_o`.
- R9: `frame_start_o` and `underrun_o` are one-cycle pulses, raised on the edge that launches the first bit of the word concerned.
- R10: During reset, `txd_o` is 1 and `bclk_o`, `frame_start_o` and `underrun_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bit rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| fsync_i | input | 1 | Transmit frame sync |
| cfg_sync_edge | input | 1 | Sync sampling edge, 0 rising, 1 falling |
| cfg_data_edge | input | 1 | Data launch edge, 0 rising, 1 falling |
| cfg_sync_low | input | 1 | Sync active level, 0 high, 1 low |
| cfg_delay | input | DLY_W | Sync-to-first-bit delay count |
| cfg_frame_len | input | FLEN_W | Frame length in bits |
| word_data | input | WORD_W | Word to transmit |
| word_valid | input | 1 | Word offered |
| word_ready | output | 1 | Word accepted this cycle if offered |
| txd_o | output | 1 | Serial transmit data |
| bclk_o | output | 1 | Generated bit clock |
| frame_start_o | output | 1 | First bit of a frame is on txd_o |
| underrun_o | output | 1 | Fill word started for lack of data |

## Verification
The assertions assume that the configuration is static while out of reset, that the frame length is nonzero and a multiple of the word width, and that the delay count is below the frame length. Under those conditions, frame starts and word boundaries are at least two cycles apart, which the pulse and ready properties depend on. The stimulus changes configuration only while reset is held. It sends syncs at a period of exactly one frame, starting from a fixed edge after release, so every detection after the first agrees with the counter's prediction. Words are offered from a known sequence, so the expected serial stream follows from the word index alone.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;

  typedef enum logic {
    EV_RISE = 1'b0,
    EV_FALL = 1'b1
  } bit_event_e;

  // Clock cycles from the sync detection edge to the first data bit,
  // wrapped into the previous frame when the count would be negative.
  function automatic int unsigned lead_ticks(int unsigned dly,
                                             int unsigned flen,
                                             int unsigned skew);
    int unsigned raw;
    raw = 2 * dly + skew;
    if (raw >= 2) return raw - 2;
    return raw + 2 * flen - 2;
  endfunction

  // Clock cycles in one frame (two per bit).
  function automatic int unsigned frame_ticks(int unsigned flen);
    return 2 * flen;
  endfunction

endpackage

// File: rtl/tdm_tx_phase.sv
module tdm_tx_phase
  import tdm_tx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sync_edge,
  input  logic data_edge,
  output logic bclk,
  output logic sync_tick,
  output logic data_tick
);

  bit_event_e ev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ev_q <= EV_RISE;
    else        ev_q <= (ev_q == EV_RISE) ? EV_FALL : EV_RISE;
  end

  // Bit clock is high after a rising event, low after a falling one.
  assign bclk      = (ev_q == EV_FALL);
  assign sync_tick = (ev_q == bit_event_e'(sync_edge));
  assign data_tick = (ev_q == bit_event_e'(data_edge));

endmodule

// File: rtl/tdm_tx_sync_track.sv
module tdm_tx_sync_track
  import tdm_tx_pkg::*;
#(
  parameter int FLEN_W = 8,
  parameter int DLY_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fsync_i,
  input  logic              sync_low,
  input  logic              skew,
  input  logic              sync_tick,
  input  logic              data_tick,
  input  logic [DLY_W-1:0]  cfg_delay,
  input  logic [FLEN_W-1:0] cfg_frame_len,
  output logic              sync_det,
  output logic              frame_start
);

  localparam int CW = FLEN_W + 1;

  logic          prev_act_q;
  logic          locked_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] off_now;
  logic [CW-1:0] start_off;
  logic [CW-1:0] last_off;
  logic          active;

  assign active    = fsync_i ^ sync_low;
  assign sync_det  = sync_tick & active & ~prev_act_q;
  assign off_now   = sync_det ? '0 : cnt_q;
  assign last_off  = CW'(frame_ticks(32'(cfg_frame_len)) - 1);
  assign start_off = CW'(lead_ticks(32'(cfg_delay), 32'(cfg_frame_len),
                                    32'(skew)));
  assign frame_start = (locked_q | sync_det) & data_tick
                       & (off_now == start_off);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_act_q <= 1'b0;
      locked_q   <= 1'b0;
      cnt_q      <= '0;
    end else begin
      if (sync_tick) prev_act_q <= active;
      if (sync_det)  locked_q   <= 1'b1;
      cnt_q <= (off_now >= last_off) ? '0 : off_now + 1'b1;
    end
  end

endmodule

// File: rtl/tdm_tx_word_feed.sv
module tdm_tx_word_feed #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_load,
  input  logic              running,
  input  logic              at_last,
  input  logic [WORD_W-1:0] word_data,
  input  logic              word_valid,
  output logic              word_ready,
  output logic [WORD_W-1:0] next_word,
  output logic              next_ok
);

  logic              full_q;
  logic [WORD_W-1:0] stage_q;
  logic              take;

  assign word_ready = ~full_q & (~running | at_last);
  assign take       = word_ready & word_valid;
  assign next_ok    = full_q | take;
  assign next_word  = full_q ? stage_q : word_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q  <= 1'b0;
      stage_q <= '0;
    end else if (word_load) begin
      full_q <= 1'b0;
    end else if (take) begin
      full_q  <= 1'b1;
      stage_q <= word_data;
    end
  end

endmodule

// File: rtl/tdm_tx_serializer.sv
module tdm_tx_serializer #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_load,
  input  logic              frame_start,
  input  logic              data_tick,
  input  logic [WORD_W-1:0] next_word,
  input  logic              next_ok,
  output logic              txd,
  output logic              running,
  output logic              at_last,
  output logic              fs_pulse,
  output logic              ur_pulse
);

  localparam int BW = (WORD_W > 2) ? $clog2(WORD_W) : 1;
  localparam logic [BW-1:0] LAST_IDX = BW'(WORD_W - 1);

  logic [WORD_W-1:0] sh_q;
  logic [BW-1:0]     left_q;
  logic [WORD_W-1:0] fill;

  assign fill    = next_ok ? next_word : '1;
  assign at_last = running & (left_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q     <= '1;
      left_q   <= '0;
      txd      <= 1'b1;
      running  <= 1'b0;
      fs_pulse <= 1'b0;
      ur_pulse <= 1'b0;
    end else begin
      fs_pulse <= 1'b0;
      ur_pulse <= 1'b0;
      if (word_load) begin
        txd      <= fill[WORD_W-1];
        sh_q     <= {fill[WORD_W-2:0], 1'b1};
        left_q   <= LAST_IDX;
        running  <= 1'b1;
        fs_pulse <= frame_start;
        ur_pulse <= ~next_ok;
      end else if (data_tick && running && left_q != '0) begin
        txd    <= sh_q[WORD_W-1];
        sh_q   <= {sh_q[WORD_W-2:0], 1'b1};
        left_q <= left_q - 1'b1;
      end
    end
  end

endmodule

// File: rtl/tdm_tx_aligner.sv
module tdm_tx_aligner #(
  parameter int WORD_W = 8,
  parameter int FLEN_W = 8,
  parameter int DLY_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fsync_i,
  input  logic              cfg_sync_edge,
  input  logic              cfg_data_edge,
  input  logic              cfg_sync_low,
  input  logic [DLY_W-1:0]  cfg_delay,
  input  logic [FLEN_W-1:0] cfg_frame_len,
  input  logic [WORD_W-1:0] word_data,
  input  logic              word_valid,
  output logic              word_ready,
  output logic              txd_o,
  output logic              bclk_o,
  output logic              frame_start_o,
  output logic              underrun_o
);

  logic              sync_tick;
  logic              data_tick;
  logic              sync_det;
  logic              frame_start;
  logic              word_load;
  logic              running;
  logic              at_last;
  logic              next_ok;
  logic [WORD_W-1:0] next_word;
  logic              skew;

  assign skew      = cfg_sync_edge ^ cfg_data_edge;
  assign word_load = frame_start | (data_tick & at_last);

  tdm_tx_phase u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_edge (cfg_sync_edge),
    .data_edge (cfg_data_edge),
    .bclk      (bclk_o),
    .sync_tick (sync_tick),
    .data_tick (data_tick)
  );

  tdm_tx_sync_track #(.FLEN_W(FLEN_W), .DLY_W(DLY_W)) u_track (
    .clk           (clk),
    .rst_n         (rst_n),
    .fsync_i       (fsync_i),
    .sync_low      (cfg_sync_low),
    .skew          (skew),
    .sync_tick     (sync_tick),
    .data_tick     (data_tick),
    .cfg_delay     (cfg_delay),
    .cfg_frame_len (cfg_frame_len),
    .sync_det      (sync_det),
    .frame_start   (frame_start)
  );

  tdm_tx_word_feed #(.WORD_W(WORD_W)) u_feed (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_load  (word_load),
    .running    (running),
    .at_last    (at_last),
    .word_data  (word_data),
    .word_valid (word_valid),
    .word_ready (word_ready),
    .next_word  (next_word),
    .next_ok    (next_ok)
  );

  tdm_tx_serializer #(.WORD_W(WORD_W)) u_ser (
    .clk         (clk),
    .rst_n       (rst_n),
    .word_load   (word_load),
    .frame_start (frame_start),
    .data_tick   (data_tick),
    .next_word   (next_word),
    .next_ok     (next_ok),
    .txd         (txd_o),
    .running     (running),
    .at_last     (at_last),
    .fs_pulse    (frame_start_o),
    .ur_pulse    (underrun_o)
  );

endmodule

// File: rtl/tdm_tx_aligner_chk.sv
module tdm_tx_aligner_chk (
  input logic clk,
  input logic rst_n,
  input logic bclk_o,
  input logic txd_o,
  input logic frame_start_o,
  input logic underrun_o,
  input logic word_ready,
  input logic word_valid,
  input logic data_tick,
  input logic sync_det,
  input logic running
);

  // R1: bit clock flips on every clock edge
  a_r1_bclk_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (bclk_o != $past(bclk_o)));

  // R6: the serial line moves only on data-edge events
  a_r6_txd_holds_off_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !data_tick |=> $stable(txd_o));

  // R5: idle ones until the first word has been launched
  a_r5_idle_before_run: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> txd_o);

  // R7: after a transfer the block accepts nothing on the next cycle
  a_r7_one_word_staged: assert property (@(posedge clk) disable iff (!rst_n)
    (word_ready && word_valid) |=> !word_ready);

  // R8: a fill word starts with a one on the line
  a_r8_fill_is_ones: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_o |-> txd_o);

  // R9: pulses last a single cycle
  a_r9_frame_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_o |=> !frame_start_o);
  a_r9_underrun_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_o |=> !underrun_o);

  // R2: detections are at least one full bit apart
  a_r2_detect_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    sync_det |=> !sync_det);

endmodule

bind tdm_tx_aligner tdm_tx_aligner_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bclk_o        (bclk_o),
  .txd_o         (txd_o),
  .frame_start_o (frame_start_o),
  .underrun_o    (underrun_o),
  .word_ready    (word_ready),
  .word_valid    (word_valid),
  .data_tick     (data_tick),
  .sync_det      (sync_det),
  .running       (running)
);

// File: tb/sim_tdm_tx_aligner.sv
`timescale 1ns/1ps
module sim_tdm_tx_aligner;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fsync_i = 1'b0;
  logic       cfg_sync_edge = 1'b0, cfg_data_edge = 1'b0, cfg_sync_low = 1'b0;
  logic [3:0] cfg_delay = 4'd1;
  logic [7:0] cfg_frame_len = 8'd16;
  logic [7:0] word_data = 8'h00;
  logic       word_valid = 1'b0;
  logic       word_ready, txd_o, bclk_o, frame_start_o, underrun_o;

  always #2.5 clk = ~clk;

  tdm_tx_aligner u0 (
    .clk(clk), .rst_n(rst_n), .fsync_i(fsync_i),
    .cfg_sync_edge(cfg_sync_edge), .cfg_data_edge(cfg_data_edge),
    .cfg_sync_low(cfg_sync_low), .cfg_delay(cfg_delay),
    .cfg_frame_len(cfg_frame_len), .word_data(word_data),
    .word_valid(word_valid), .word_ready(word_ready), .txd_o(txd_o),
    .bclk_o(bclk_o), .frame_start_o(frame_start_o), .underrun_o(underrun_o)
  );

  int  n_chk = 0, n_bad = 0;
  int  ecnt = 0;
  int  widx = 0, feed_limit = 1000;
  bit  pend = 0;
  bit  sync_on = 0;
  int  ks = 20, per = 32, swid = 2;

  always @(posedge clk) begin
    if (!rst_n) ecnt <= 0;
    else        ecnt <= ecnt + 1;
  end

  function automatic logic [7:0] pat(int i);
    return 8'((i * 53 + 195) % 256);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drivers for the edge about to come; called at a falling clock edge.
  task automatic drive();
    int u;
    bit act;
    if (pend) widx++;
    word_data  = pat(widx);
    word_valid = (widx < feed_limit);
    pend       = word_ready && word_valid;
    u   = ecnt;
    act = sync_on && (u >= ks) && (((u - ks) % per) < swid);
    fsync_i = act ^ cfg_sync_low;
  endtask

  task automatic step();
    @(negedge clk);
    drive();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; pend = 0; widx = 0; word_valid = 1'b0;
    fsync_i = cfg_sync_low;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    drive();
  endtask

  // se, de, sl, delay, frame length, expected frame-start edge
  typedef struct packed {
    logic       se; logic de; logic sl;
    logic [3:0] dly; logic [7:0] flen; logic [15:0] kf;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 1'b0, 1'b0, 4'd1, 8'd16, 16'd20},
    '{1'b0, 1'b1, 1'b0, 4'd1, 8'd16, 16'd21},
    '{1'b1, 1'b0, 1'b1, 4'd2, 8'd16, 16'd24},
    '{1'b1, 1'b1, 1'b1, 4'd3, 8'd24, 16'd25},
    '{1'b0, 1'b0, 1'b0, 4'd0, 8'd16, 16'd50},
    '{1'b0, 1'b1, 1'b1, 4'd0, 8'd8,  16'd35}
  };

  task automatic setup(logic se, logic de, logic sl, logic [3:0] d,
                       logic [7:0] fl, int limit);
    cfg_sync_edge = se; cfg_data_edge = de; cfg_sync_low = sl;
    cfg_delay = d; cfg_frame_len = fl;
    ks = 20 + int'(se); per = 2 * int'(fl); swid = 2;
    sync_on = 1; feed_limit = limit;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=done", ecnt);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R10: state held in reset
    repeat (2) @(negedge clk);
    chk(txd_o === 1'b1, "R10 txd", txd_o, 1);
    chk(bclk_o === 1'b0 && frame_start_o === 1'b0 && underrun_o === 1'b0,
        "R10 pulses", {bclk_o, frame_start_o, underrun_o}, 0);

    // Vector table walk: R3, R4, R5, R6, R2
    foreach (VECS[i]) begin
      int fs;
      logic [15:0] bits;
      bit idle_ok;
      vec_t v;
      v = VECS[i];
      setup(v.se, v.de, v.sl, v.dly, v.flen, 1000);
      do_reset();
      fs = -1; bits = '0; idle_ok = 1;
      for (int n = 0; n < 300; n++) begin
        int l;
        step();
        l = ecnt - 1;
        if (fs < 0 && frame_start_o) fs = l;
        if (fs < 0 && txd_o !== 1'b1) idle_ok = 0;
        if (fs >= 0 && ((l - fs) % 2 == 0) && (l - fs) / 2 < 16)
          bits[15 - (l - fs) / 2] = txd_o;
        if (fs >= 0 && l > fs + 34) break;
      end
      if (v.dly == 0) chk(fs == int'(v.kf), "R4 first bit edge", fs, int'(v.kf));
      else            chk(fs == int'(v.kf), "R3 first bit edge", fs, int'(v.kf));
      if (v.sl) chk(fs == int'(v.kf), "R2 low-active sync", fs, int'(v.kf));
      chk(bits == {pat(0), pat(1)}, "R6 serial stream", bits, {pat(0), pat(1)});
      chk(idle_ok, "R5 idle before frame", idle_ok, 1);
    end

    // R1: bit clock phase after release
    setup(1'b0, 1'b0, 1'b0, 4'd1, 8'd16, 1000);
    sync_on = 0;
    do_reset();
    step();
    chk(bclk_o === 1'b1, "R1 after first edge", bclk_o, 1);
    step();
    chk(bclk_o === 1'b0, "R1 after second edge", bclk_o, 0);

    // R5 and R7: no sync ever, word staged, nothing sent
    begin
      bit quiet = 1;
      for (int n = 0; n < 100; n++) begin
        step();
        if (frame_start_o || txd_o !== 1'b1) quiet = 0;
      end
      chk(quiet, "R5 no sync no frame", quiet, 1);
      chk(word_ready === 1'b0, "R7 staging full", word_ready, 0);
    end

    // R2: a one-cycle pulse seen only on falling events is never sampled
    setup(1'b0, 1'b0, 1'b0, 4'd1, 8'd16, 1000);
    ks = 21; swid = 1;
    do_reset();
    begin
      bit quiet = 1;
      for (int n = 0; n < 120; n++) begin
        step();
        if (frame_start_o) quiet = 0;
      end
      chk(quiet, "R2 wrong edge ignored", quiet, 1);
    end

    // R2: sync held at its inactive level (low-active, line high)
    setup(1'b0, 1'b0, 1'b1, 4'd1, 8'd16, 1000);
    sync_on = 0;
    do_reset();
    begin
      bit quiet = 1;
      for (int n = 0; n < 120; n++) begin
        step();
        if (frame_start_o || txd_o !== 1'b1) quiet = 0;
      end
      chk(quiet, "R2 inactive level ignored", quiet, 1);
    end

    // R7, R8, R9: a single word supplied, then starvation
    setup(1'b0, 1'b0, 1'b0, 4'd1, 8'd16, 1);
    do_reset();
    begin
      bit ones_ok = 1;
      for (int n = 0; n < 60; n++) begin
        int l;
        step();
        l = ecnt - 1;
        if (l == 5)  chk(word_ready === 1'b0, "R7 ready low while staged", word_ready, 0);
        if (l == 20) chk(frame_start_o === 1'b1, "R9 frame pulse", frame_start_o, 1);
        if (l == 21) chk(frame_start_o === 1'b0, "R9 frame pulse width", frame_start_o, 0);
        if (l == 34) chk(word_ready === 1'b1, "R7 ready on last bit", word_ready, 1);
        if (l == 36) chk(underrun_o === 1'b1, "R8 underrun flag", underrun_o, 1);
        if (l == 37) chk(underrun_o === 1'b0, "R9 underrun width", underrun_o, 0);
        if (l >= 36 && l <= 51 && txd_o !== 1'b1) ones_ok = 0;
      end
      chk(ones_ok, "R8 fill of ones", ones_ok, 1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule